// File: doc/BRIEF.md
# Serial-Bus Control Register Bank with Deferred Commit

This block is the control and status store of a clock synthesizer, reached over a two-wire I2C bus as a slave. It answers to a 7-bit device address whose top six bits are fixed and whose last bit comes from a strap pin. Two such devices can therefore share one bus. Inside the device, a byte-wide word pointer selects a location. A page write or a sequential read moves the pointer forward by one per byte, and the pointer stays inside its 16-location page.

Most locations take effect as soon as they are written. The four that set up the loop are different: a written byte waits in a pending copy and reaches the loop outputs only when a fixed key byte lands on a command location. That key write also sends a one-cycle restart pulse to the loop. Two status locations report a constant revision code and the live lock level of the loop.

SCL and SDA are brought in through two-flop synchronizers and sampled on the system clock. The slave pulls SDA low through an open-drain enable.

Top module: `clksyn_i2c_regbank`

## Requirements
- R1: The slave acknowledges only the device address 0b010011s, where s is `addr_sel_i`, followed by the R/W bit (1 = read). For any other device address it leaves SDA released for the whole transaction, and the data bytes that follow change nothing.
- R2: In a write transaction, the first byte after the device address loads the word pointer. Each byte after that is stored at the pointer, acknowledged, and advances the pointer by one.
- R3: The pointer advances only in its low four bits, so 0Fh is followed by 00h and 1Fh by 10h.
- R4: After reset, location 00h holds 41h, location 05h holds 01h, and locations 01h–04h, 06h and 07h hold 00h. The outputs present these values and `loop_rst_o` is low.
- R5: Bytes written to 00h, 04h, 06h and 07h take effect at once. `ctrl_o` shows 00h and `out_en_o` shows bit 1 of 06h.
- R6: Bytes written to 01h, 02h, 03h and 05h are held as pending values and leave `loop_cfg_o`, `fb_div_o` and `trig_cfg_o` unchanged. A read of these locations returns the pending value.
- R7: Writing 5Ah to 08h copies every pending value to the loop outputs and raises `loop_rst_o` for exactly one cycle. `loop_cfg_o` shows 01h, `trig_cfg_o` shows 05h, and `fb_div_o` is {03h[3:0], 02h}.
- R8: Any other byte written to 08h has no effect. Reads of 08h return 00h.
- R9: Location 11h reads 01h. Location 12h reads lock status in bit 1 with all other bits 0. Location 10h reads 00h. Writes to 10h–12h are acknowledged and ignored.
- R10: The reserved locations 09h–0Fh and 13h–1Fh read 00h and ignore writes.
- R11: A read transaction returns the byte at the pointer and advances the pointer once per byte sent. It continues while the master acknowledges and ends on a NACK. A read with no pointer byte continues from where the last access left off.
- R12: A write of the pointer byte followed by a repeated START and a read address returns data starting at that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| addr_sel_i | input | 1 | Strap for device address bit 0 |
| lock_i | input | 1 | Live loop lock status |
| ctrl_o | output | 8 | Contents of location 00h |
| loop_cfg_o | output | 8 | Committed value of 01h |
| fb_div_o | output | 12 | Committed feedback divider code |
| trig_cfg_o | output | 8 | Committed value of 05h |
| out_en_o | output | 1 | Output enable, bit 1 of 06h |
| loop_rst_o | output | 1 | One-cycle loop restart pulse on commit |

## Verification
The commit strobe and the pointer advance both fall in the cycle in which the key byte completes. In a single page write running from 01h to 08h, the loop values and the key therefore arrive inside one transaction. The bench checks three things: the loop outputs carry the bytes written earlier in that same transaction, exactly one restart pulse appears, and a following current-address read starts at 09h and returns 00h. A bench-side model of the pending copies, the committed copies and the pointer gives the expected value for every read and every output.

// File: rtl/clksyn_regs_pkg.sv
package clksyn_regs_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned RW_N  = 8;
  localparam int unsigned AW    = $clog2(RW_N);
  localparam logic [5:0]  DEV_ID_HI  = 6'b010011;
  localparam logic [DW-1:0] CMD_ADDR   = 8'h08;
  localparam logic [DW-1:0] COMMIT_KEY = 8'h5A;
  localparam logic [DW-1:0] REV_ADDR   = 8'h11;
  localparam logic [DW-1:0] STAT_ADDR  = 8'h12;
  localparam logic [DW-1:0] REV_VAL    = 8'h01;
  // locations held pending until commit
  localparam logic [RW_N-1:0] SHADOW_MASK = 8'b0010_1110;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK
  } bus_state_e;

  function automatic logic [DW-1:0] rw_reset(input int unsigned idx);
    case (idx)
      0:       return 8'h41;
      5:       return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // advance inside the 16-location page
  function automatic logic [DW-1:0] ptr_next(input logic [DW-1:0] p);
    return {p[DW-1:4], p[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/clksyn_bus_sync.sv
module clksyn_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_sr[STAGES-1];
      sda_d  <= sda_sr[STAGES-1];
    end
  end

  assign scl_s      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/clksyn_bus_fsm.sv
module clksyn_bus_fsm
  import clksyn_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          addr_sel_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          sda_oe_o,
  output logic          ptr_ld_o,
  output logic          wr_stb_o,
  output logic          rd_adv_o,
  output logic [DW-1:0] byte_o
);
  bus_state_e    st_q;
  logic [DW-1:0] sh_q, tx_q;
  logic [3:0]    cnt_q;
  logic          first_q, oe_q, ptr_ld_q, wr_stb_q, rd_adv_q;
  logic          addr_hit;

  assign addr_hit = (sh_q[7:1] == {DEV_ID_HI, addr_sel_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      sh_q     <= '0;
      tx_q     <= '0;
      cnt_q    <= '0;
      first_q  <= 1'b0;
      oe_q     <= 1'b0;
      ptr_ld_q <= 1'b0;
      wr_stb_q <= 1'b0;
      rd_adv_q <= 1'b0;
    end else begin
      ptr_ld_q <= 1'b0;
      wr_stb_q <= 1'b0;
      rd_adv_q <= 1'b0;
      if (start_i) begin
        st_q  <= S_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_i) begin
        st_q <= S_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (st_q)
          S_ADDR, S_RX: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (st_q == S_ADDR) begin
                if (addr_hit) begin
                  st_q <= S_AACK;
                  oe_q <= 1'b1;
                end else begin
                  st_q <= S_IDLE;
                end
              end else begin
                st_q     <= S_RACK;
                oe_q     <= 1'b1;
                ptr_ld_q <= first_q;
                wr_stb_q <= ~first_q;
                first_q  <= 1'b0;
              end
            end
          end
          S_AACK: if (scl_fall_i) begin
            if (sh_q[0]) begin
              st_q     <= S_TX;
              tx_q     <= rd_data_i;
              oe_q     <= ~rd_data_i[7];
              rd_adv_q <= 1'b1;
            end else begin
              st_q    <= S_RX;
              oe_q    <= 1'b0;
              first_q <= 1'b1;
            end
          end
          S_RACK: if (scl_fall_i) begin
            st_q <= S_RX;
            oe_q <= 1'b0;
          end
          S_TX: if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              cnt_q <= '0;
              oe_q  <= 1'b0;
              st_q  <= S_TACK;
            end else begin
              cnt_q <= cnt_q + 4'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= ~tx_q[6];
            end
          end
          S_TACK: begin
            if (scl_rise_i && sda_i) begin
              st_q <= S_IDLE;   // master NACK ends the read
            end else if (scl_fall_i) begin
              st_q     <= S_TX;
              tx_q     <= rd_data_i;
              oe_q     <= ~rd_data_i[7];
              rd_adv_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign ptr_ld_o = ptr_ld_q;
  assign wr_stb_o = wr_stb_q;
  assign rd_adv_o = rd_adv_q;
  assign byte_o   = sh_q;
endmodule

// File: rtl/clksyn_reg_core.sv
module clksyn_reg_core
  import clksyn_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_ld_i,
  input  logic          wr_stb_i,
  input  logic          rd_adv_i,
  input  logic [DW-1:0] byte_i,
  input  logic          lock_i,
  output logic [DW-1:0] rd_data_o,
  output logic [7:0]    ctrl_o,
  output logic [7:0]    loop_cfg_o,
  output logic [11:0]   fb_div_o,
  output logic [7:0]    trig_cfg_o,
  output logic          out_en_o,
  output logic          loop_rst_o
);
  logic [DW-1:0] ptr_q;
  logic [DW-1:0] rw_v  [RW_N];
  logic [DW-1:0] act_v [RW_N];
  logic [1:0]    lock_sr;
  logic          in_rw, wr_rw, commit, commit_q;

  assign in_rw  = (ptr_q[DW-1:AW] == '0);
  assign wr_rw  = wr_stb_i & in_rw;
  assign commit = wr_stb_i && ptr_q == CMD_ADDR && byte_i == COMMIT_KEY;

  for (genvar i = 0; i < RW_N; i++) begin : g_cell
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= rw_reset(i);
      else if (wr_rw && ptr_q[AW-1:0] == AW'(i)) q <= byte_i;
    end
    assign rw_v[i] = q;
    if (SHADOW_MASK[i]) begin : g_pend
      logic [DW-1:0] a;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) a <= rw_reset(i);
        else if (commit) a <= q;
      end
      assign act_v[i] = a;
    end else begin : g_live
      assign act_v[i] = q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      commit_q <= 1'b0;
      lock_sr  <= '0;
    end else begin
      commit_q <= commit;
      lock_sr  <= {lock_sr[0], lock_i};
      if (ptr_ld_i) ptr_q <= byte_i;
      else if (wr_stb_i || rd_adv_i) ptr_q <= ptr_next(ptr_q);
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (in_rw) rd_data_o = rw_v[ptr_q[AW-1:0]];
    else if (ptr_q == REV_ADDR) rd_data_o = REV_VAL;
    else if (ptr_q == STAT_ADDR) rd_data_o = {6'b0, lock_sr[1], 1'b0};
  end

  assign ctrl_o     = act_v[0];
  assign loop_cfg_o = act_v[1];
  assign fb_div_o   = {act_v[3][3:0], act_v[2]};
  assign trig_cfg_o = act_v[5];
  assign out_en_o   = act_v[6][1];
  assign loop_rst_o = commit_q;
endmodule

// File: rtl/clksyn_i2c_regbank.sv
module clksyn_i2c_regbank
  import clksyn_regs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic        addr_sel_i,
  input  logic        lock_i,
  output logic [7:0]  ctrl_o,
  output logic [7:0]  loop_cfg_o,
  output logic [11:0] fb_div_o,
  output logic [7:0]  trig_cfg_o,
  output logic        out_en_o,
  output logic        loop_rst_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_ld, wr_stb, rd_adv;
  logic [DW-1:0] bus_byte, rd_data;

  clksyn_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  clksyn_bus_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .addr_sel_i (addr_sel_i),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .ptr_ld_o   (ptr_ld),
    .wr_stb_o   (wr_stb),
    .rd_adv_o   (rd_adv),
    .byte_o     (bus_byte)
  );

  clksyn_reg_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_ld_i   (ptr_ld),
    .wr_stb_i   (wr_stb),
    .rd_adv_i   (rd_adv),
    .byte_i     (bus_byte),
    .lock_i     (lock_i),
    .rd_data_o  (rd_data),
    .ctrl_o     (ctrl_o),
    .loop_cfg_o (loop_cfg_o),
    .fb_div_o   (fb_div_o),
    .trig_cfg_o (trig_cfg_o),
    .out_en_o   (out_en_o),
    .loop_rst_o (loop_rst_o)
  );
endmodule

// File: rtl/clksyn_i2c_regbank_chk.sv
module clksyn_i2c_regbank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_i,
  input logic        sda_oe_o,
  input logic        wr_stb,
  input logic [7:0]  ctrl_o,
  input logic [7:0]  loop_cfg_o,
  input logic [11:0] fb_div_o,
  input logic [7:0]  trig_cfg_o,
  input logic        out_en_o,
  input logic        loop_rst_o
);
  assert_shadow_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_rst_o |-> $stable({loop_cfg_o, fb_div_o, trig_cfg_o}));

  assert_commit_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_rst_o |=> !loop_rst_o);

  assert_commit_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_rst_o |-> $past(wr_stb));

  assert_direct_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_stb) |-> ($stable(ctrl_o) && $stable(out_en_o)));

  assert_sda_low_phase_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind clksyn_i2c_regbank clksyn_i2c_regbank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .wr_stb     (wr_stb),
  .ctrl_o     (ctrl_o),
  .loop_cfg_o (loop_cfg_o),
  .fb_div_o   (fb_div_o),
  .trig_cfg_o (trig_cfg_o),
  .out_en_o   (out_en_o),
  .loop_rst_o (loop_rst_o)
);

// File: tb/sim_clksyn_i2c_regbank.sv
module sim_clksyn_i2c_regbank;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0, lock = 1'b0;
  logic sda_oe, out_en, loop_rst;
  logic [7:0] ctrl, loop_cfg, trig_cfg;
  logic [11:0] fb_div;
  wire sda_w = m_sda & ~sda_oe;

  clksyn_i2c_regbank u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_w), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .lock_i(lock), .ctrl_o(ctrl), .loop_cfg_o(loop_cfg),
    .fb_div_o(fb_div), .trig_cfg_o(trig_cfg), .out_en_o(out_en), .loop_rst_o(loop_rst)
  );

  int n_chk = 0, n_bad = 0, pulses = 0, exp_pulses = 0;
  bit done = 0;
  logic [6:0] dev = 7'b0100110;
  logic [7:0] mdl [0:7];
  logic [7:0] act [0:7];
  logic [7:0] mptr;
  logic [7:0] wbuf [0:15];

  always @(posedge clk) if (rst_n && loop_rst) pulses++;

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, a, e);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return {p[7:4], p[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a < 8) return mdl[a[2:0]];
    if (a == 8'h11) return 8'h01;
    if (a == 8'h12) return {6'b0, lock, 1'b0};
    return 8'h00;
  endfunction

  task automatic mdl_wr(input logic [7:0] a, input logic [7:0] d);
    if (a < 8) mdl[a[2:0]] = d;
    else if (a == 8'h08 && d == 8'h5A) begin
      act[1] = mdl[1]; act[2] = mdl[2]; act[3] = mdl[3]; act[5] = mdl[5];
      exp_pulses++;
    end
  endtask

  task automatic qwait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    m_sda = b; qwait;
    m_scl = 1'b1; qwait;
    r = sda_w; qwait;
    m_scl = 1'b0; qwait;
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; qwait;
    m_scl = 1'b1; qwait;
    m_sda = 1'b0; qwait;
    m_scl = 1'b0; qwait;
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; qwait;
    m_scl = 1'b1; qwait;
    m_sda = 1'b1; qwait;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, r);
      d = {d[6:0], r};
    end
    bus_bit(last, r);
  endtask

  task automatic i2c_write(input string tag, input logic [7:0] a, input int n);
    logic ack, all_ack;
    all_ack = 1'b1;
    i2c_start;
    wr_byte({dev, 1'b0}, ack); all_ack &= ack;
    wr_byte(a, ack); all_ack &= ack;
    mptr = a;
    for (int k = 0; k < n; k++) begin
      wr_byte(wbuf[k], ack); all_ack &= ack;
      mdl_wr(mptr, wbuf[k]);
      mptr = nxt(mptr);
    end
    i2c_stop;
    chk({tag, " ack"}, all_ack, 1'b1);
  endtask

  task automatic i2c_read(input string tag, input logic [7:0] a, input int n, input bit setp);
    logic ack, all_ack;
    logic [7:0] d;
    all_ack = 1'b1;
    i2c_start;
    if (setp) begin
      wr_byte({dev, 1'b0}, ack); all_ack &= ack;
      wr_byte(a, ack); all_ack &= ack;
      mptr = a;
      i2c_start;
    end
    wr_byte({dev, 1'b1}, ack); all_ack &= ack;
    for (int k = 0; k < n; k++) begin
      rd_byte(k == n - 1, d);
      chk($sformatf("%s read %0h", tag, mptr), d, exp_rd(mptr));
      mptr = nxt(mptr);
    end
    i2c_stop;
    chk({tag, " ack"}, all_ack, 1'b1);
  endtask

  task automatic chk_outs(input string tag);
    repeat (4) @(negedge clk);
    chk({tag, " ctrl"}, ctrl, mdl[0]);
    chk({tag, " out_en"}, out_en, mdl[6][1]);
    chk({tag, " loop_cfg"}, loop_cfg, act[1]);
    chk({tag, " fb_div"}, fb_div, {act[3][3:0], act[2]});
    chk({tag, " trig_cfg"}, trig_cfg, act[5]);
    chk({tag, " pulses"}, pulses, exp_pulses);
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 8; i++) begin
      mdl[i] = (i == 0) ? 8'h41 : (i == 5) ? 8'h01 : 8'h00;
      act[i] = mdl[i];
    end
    mptr = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4 reset state
    chk_outs("R4");
    chk("R4 sda_oe", sda_oe, 1'b0);

    // R1 foreign address is not acknowledged, following data is ignored
    i2c_start;
    wr_byte(8'h4E, ack);
    chk("R1 nack 4E", ack, 1'b0);
    wr_byte(8'h00, ack);
    wr_byte(8'hFF, ack);
    i2c_stop;
    i2c_start;
    wr_byte(8'hA0, ack);
    chk("R1 nack A0", ack, 1'b0);
    i2c_stop;
    chk_outs("R1");

    // R1 strap high selects the other address
    addr_sel = 1'b1; dev = 7'b0100111;
    wbuf[0] = 8'h02;
    i2c_write("R1 sel1 R5", 8'h06, 1);
    i2c_start;
    wr_byte(8'h4C, ack);
    chk("R1 nack 4C with sel1", ack, 1'b0);
    i2c_stop;
    addr_sel = 1'b0; dev = 7'b0100110;
    chk_outs("R5 out_en");

    // R5 immediate location
    wbuf[0] = 8'h3C;
    i2c_write("R5", 8'h00, 1);
    chk_outs("R5");

    // R2 page write, R6 pending hold and readback
    wbuf[0] = 8'h05; wbuf[1] = 8'h34; wbuf[2] = 8'h12; wbuf[3] = 8'h77; wbuf[4] = 8'h80;
    i2c_write("R2", 8'h01, 5);
    chk_outs("R6");
    i2c_read("R6", 8'h01, 5, 1);

    // R8 wrong key
    wbuf[0] = 8'h33;
    i2c_write("R8", 8'h08, 1);
    chk_outs("R8");
    i2c_read("R8", 8'h08, 1, 1);

    // R7 commit
    wbuf[0] = 8'h5A;
    i2c_write("R7", 8'h08, 1);
    chk_outs("R7");

    // R7 values and key in one page write; pointer then at 09h
    wbuf[0] = 8'h09; wbuf[1] = 8'h56; wbuf[2] = 8'h0A; wbuf[3] = 8'h77;
    wbuf[4] = 8'h40; wbuf[5] = 8'h02; wbuf[6] = 8'h00; wbuf[7] = 8'h5A;
    i2c_write("R7 page", 8'h01, 8);
    chk_outs("R7 page");
    i2c_read("R11 after commit", 8'h00, 1, 0);

    // R3 wrap inside page
    wbuf[0] = 8'h11; wbuf[1] = 8'h55;
    i2c_write("R3", 8'h0F, 2);
    chk_outs("R3");
    i2c_read("R3 p0", 8'h0F, 2, 1);
    i2c_read("R3 p1", 8'h1F, 3, 1);

    // R9 status locations
    lock = 1'b1;
    repeat (5) @(negedge clk);
    i2c_read("R9", 8'h10, 3, 1);
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    i2c_write("R9", 8'h11, 2);
    i2c_read("R9 after wr", 8'h11, 2, 1);
    lock = 1'b0;
    repeat (5) @(negedge clk);
    i2c_read("R9 unlock", 8'h12, 1, 1);

    // R10 reserved locations
    wbuf[0] = 8'hFF;
    i2c_write("R10", 8'h0A, 1);
    wbuf[0] = 8'hEE;
    i2c_write("R10", 8'h1C, 1);
    i2c_read("R10", 8'h09, 4, 1);
    chk_outs("R10");

    // R11 sequential then current-address continuation
    i2c_read("R11", 8'h00, 3, 1);
    i2c_read("R11 cont", 8'h00, 2, 0);

    // R12 full sweep of both pages through repeated start
    i2c_read("R12 page0", 8'h00, 16, 1);
    i2c_read("R12 page1", 8'h10, 16, 1);
    chk_outs("R12");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule